// File: doc/BRIEF.md
# UART Interrupt Source Aggregator

This block collects the four interrupt causes of one serial channel into a source register, gates them with a mask, and drives one level-sensitive interrupt line. The four causes are receive, error, transmit and modem. Neighbouring logic reports each cause as a one-cycle set pulse. Software writes the mask and clears causes through a small register write port.

The block also makes the transmit request itself. While FIFO mode is on, it compares the transmit FIFO occupancy with a threshold. The threshold is a 3-bit trigger field multiplied by a factor that depends on the channel number, which is fixed at elaboration. The transmit cause is set on every cycle in which the occupancy is at or below that threshold, so it works as a level request and not as an edge.

There is no data stream through the block. All pins are plain control and status signals, and none of them has a handshake or back-pressure.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source register, the mask and the pending vector are all zero, and `irq` is low.
- R2: Bit positions are fixed: bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. A 1 on `ev_set[i]` sets source bit i at the next clock edge.
- R3: `int_pend` always equals `src_pend & ~mask`, with no added latency after the registers update.
- R4: `irq` is high exactly while `int_pend` is nonzero.
- R5: A write with `reg_sel`=0 loads `reg_wdata` into the mask at the next edge.
- R6: A write with `reg_sel`=1 (pending register) clears every source bit, and therefore every pending bit, that is 1 in `reg_wdata`.
- R7: A write with `reg_sel`=2 (source register) clears the source bits that are 1 in `reg_wdata`. A write with `reg_sel`=3 changes nothing.
- R8: If a set and a clear hit the same source bit in one cycle, the set wins and the bit reads 1.
- R9: The transmit threshold is `tx_trig` times a channel factor. The factor is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3.
- R10: While `fifo_en` is 1, transmit source bit 2 is set at every edge where `tx_count` is at or below the threshold. While `fifo_en` is 0, occupancy sets nothing.
- R11: Any channel number other than 0 to 4 gives a factor of 0, so the transmit source is requested only when `tx_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 4 | One-cycle set pulses, one per cause |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 mask, 1 pending, 2 source, 3 none |
| reg_wdata | input | 4 | Write data (mask value or clear bits) |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | 3 | Transmit trigger field |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| src_pend | output | 4 | Source-pending register |
| int_pend | output | 4 | Masked pending vector |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check on every cycle that set pulses land, that clears take effect when no set competes, that the source register holds while idle, that the mask loads, that a fully masked channel keeps `irq` low, and that a met threshold always raises the transmit cause. The per-channel threshold arithmetic is shown only by the bench, which sweeps every trigger value against every occupancy for three channel factors. The bench also covers the full grid of mask and source patterns, the ignored write target, and set-versus-clear collisions.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N     = 4;
  localparam int IDX_RX    = 0;
  localparam int IDX_ERR   = 1;
  localparam int IDX_TX    = 2;
  localparam int IDX_MODEM = 3;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // per-channel multiplier applied to the transmit trigger field
  function automatic int chan_scale(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_txlvl.sv
module uart_irq_txlvl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CNT_W-1:0]  count,
  output logic              tx_req
);
  localparam int SCALE = chan_scale(CHANNEL);
  localparam int PROD_W = TRIG_W + 6;
  localparam int CMP_W  = (CNT_W > PROD_W) ? CNT_W : PROD_W;

  logic [CMP_W-1:0] thr;
  logic [CMP_W-1:0] cnt_ext;

  generate
    if (SCALE == 0) begin : g_zero
      assign thr = '0;
    end else begin : g_mul
      assign thr = CMP_W'(trig) * CMP_W'(SCALE);
    end
  endgenerate

  assign cnt_ext = CMP_W'(count);
  assign tx_req  = fifo_en && (cnt_ext <= thr);

  // an empty FIFO is always at or below any threshold
  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && count == '0) |-> tx_req);  // R10
  AST_NO_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en) |-> !tx_req);  // R10
endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] src_q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)          src_q[i] <= 1'b0;
        else if (set_vec[i]) src_q[i] <= 1'b1;
        else if (clr_vec[i]) src_q[i] <= 1'b0;
      end
    end
  endgenerate

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((src_q & $past(set_vec)) == $past(set_vec)));  // R8
  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec != '0) && ((clr_vec & set_vec) == '0)) |=> ((src_q & $past(clr_vec)) == '0));  // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(src_q));  // R2
endmodule

// File: rtl/uart_irq_maskpend.sv
module uart_irq_maskpend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] src_q,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign pend = src_q & ~mask_q;
  assign irq  = |pend;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));  // R5
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);  // R4
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int TRIG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  ev_set,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [SRC_N-1:0]  reg_wdata,
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [CNT_W-1:0]  tx_count,
  output logic [SRC_N-1:0]  src_pend,
  output logic [SRC_N-1:0]  int_pend,
  output logic              irq
);
  reg_sel_e         sel;
  logic             tx_req;
  logic             mask_we;
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;

  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    mask_we = 1'b0;
    clr_vec = '0;
    if (reg_we) begin
      case (sel)
        SEL_MASK: mask_we = 1'b1;
        SEL_PEND: clr_vec = reg_wdata;  // clears source and hence pending
        SEL_SRC:  clr_vec = reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    set_vec = ev_set;
    set_vec[IDX_TX] = ev_set[IDX_TX] | tx_req;
  end

  uart_irq_txlvl #(.CHANNEL(CHANNEL), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_txlvl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig(tx_trig),
    .count(tx_count), .tx_req(tx_req)
  );

  uart_irq_srcreg #(.N(SRC_N)) u_src (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .src_q(src_pend)
  );

  uart_irq_maskpend #(.N(SRC_N)) u_mask (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(reg_wdata),
    .src_q(src_pend), .pend(int_pend), .irq(irq)
  );

  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> src_pend[IDX_TX]);  // R10
  AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend == '0) |-> !irq);  // R4
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_pend & ~src_pend) == '0));  // R3
  AST_NOSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd3 && ev_set == '0 && !fifo_en) |=> $stable(src_pend));  // R7
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ev_set = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [3:0] reg_wdata = '0;
  logic       fifo_en = 1'b0;
  logic [2:0] tx_trig = '0;
  logic [7:0] tx_count = '0;

  logic [3:0] src0, pend0, src2, pend2, src7, pend7;
  logic       irq0, irq2, irq7;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .src_pend(src0), .int_pend(pend0), .irq(irq0));
  uart_irq_ctrl #(.CHANNEL(2)) dut_ch2 (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .src_pend(src2), .int_pend(pend2), .irq(irq2));
  uart_irq_ctrl #(.CHANNEL(7)) dut_ch7 (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .src_pend(src7), .int_pend(pend7), .irq(irq7));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; inputs are changed and outputs sampled 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ev_set = '0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    step();
    idle();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1: reset state
    chk("R1 src", int'(src0), 0);
    chk("R1 pend", int'(pend0), 0);
    chk("R1 irq", int'(irq0), 0);
    rst_n = 1'b1;
    step();

    // R2/R3/R4/R5: all source patterns against all masks
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(2'd2, 4'hF);
        ev_set = 4'(s);
        step();
        idle();
        chk("R2 src", int'(src0), s);
        wr(2'd0, 4'(m));
        chk("R3 pend", int'(pend0), s & ~m & 15);
        chk("R4 irq", int'(irq0), ((s & ~m & 15) != 0) ? 1 : 0);
      end
    end
    wr(2'd0, 4'h0);

    // R6: pending-register write clears the named bits
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, 4'hF);
      ev_set = 4'hF; step(); idle();
      wr(2'd1, 4'(c));
      chk("R6 src", int'(src0), 15 & ~c);
      chk("R6 pend", int'(pend0), 15 & ~c);
    end
    // R7: source-register write clears, target 3 ignored
    for (int c = 0; c < 16; c++) begin
      wr(2'd2, 4'hF);
      ev_set = 4'hF; step(); idle();
      wr(2'd2, 4'(c));
      chk("R7 src clear", int'(src0), 15 & ~c);
      wr(2'd3, 4'hF);
      chk("R7 target3 ignored", int'(src0), 15 & ~c);
    end
    // R8: set beats clear in the same cycle
    wr(2'd2, 4'hF);
    ev_set = 4'b0101; reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 4'hF;
    step(); idle();
    chk("R8 collision", int'(src0), 5);

    // R10: FIFO mode off, empty FIFO sets nothing
    wr(2'd2, 4'hF);
    fifo_en = 1'b0; tx_count = '0; tx_trig = 3'd7;
    step();
    chk("R10 fifo off", int'(src0), 0);

    // R9/R10/R11: threshold sweep on three channel factors
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < 256; c++) begin
        fifo_en = 1'b0;
        wr(2'd2, 4'h4);
        fifo_en = 1'b1; tx_trig = 3'(t); tx_count = 8'(c);
        step();
        chk("R9 ch0 tx", int'(src0[2]), (c <= t * 32) ? 1 : 0);
        chk("R9 ch2 tx", int'(src2[2]), (c <= t * 2) ? 1 : 0);
        chk("R11 ch7 tx", int'(src7[2]), (c == 0) ? 1 : 0);
      end
    end
    fifo_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule